// File: doc/BRIEF.md
# Interrupt-flag segment insertion cell

This cell sits at one branch point of a hierarchical, reconfigurable scan network. Like an ordinary segment insertion cell, it holds a control bit with a shift stage and an update stage. While the updated control bit is set, the scan path passes through an attached lower segment. While it is clear, that segment is bypassed. The cell adds an in-line interrupt flag that can be bypassed, together with an upward interrupt line toward the network host.

The flag joins the scan path or stays out of it according to two mode inputs. In normal access the flag is never on the path. In diagnosis mode it is always on the path, as the bit nearest `scan_out`. In localization mode the control bit leaves the path and the flag alone is presented. The lower segment is entered only when the flag is set, so a host can walk down to an interrupting instrument one flag at a time. The localization path is formed combinationally as soon as `loc_mode` is raised, with no configuration shift. The interrupt output is a combinational OR of the flag and the lower interrupt lines, so an interrupt travels upward with no clock.

Top module: `flagged_seg_gate`

## Requirements
- R1: While reset is held, and until the internal reset release that follows two clock edges after `rst_n` rises, the control bit (shift and update stage) and the flag are 0. As a result, `scan_out` is 0 and the lower segment is bypassed.
- R2: In normal access (`loc_mode`=0, `diag_mode`=0) with the segment closed, the path from `scan_in` to `scan_out` is one bit long: the control shift stage.
- R3: `seg_si` always equals `scan_in`. A clock edge with `update_en`=1 outside localization copies the control shift stage into the update stage. Once that update stage is 1, outside localization the path becomes `scan_in` → lower segment → control shift stage.
- R4: Outside localization, an edge with `capture_en`=1 loads the control shift stage with the update stage.
- R5: With `diag_mode`=1 and `loc_mode`=0, the flag is appended after the control shift stage, and `scan_out` shows the flag. On every edge with `capture_en`=1, in any mode, the flag loads the OR of all `irq_in` lines.
- R6: `irq_out` is the combinational OR of the flag and every `irq_in` line.
- R7: With `loc_mode`=1 and the flag clear, the path is the flag alone: `scan_out` equals the flag, and the lower segment is bypassed whatever the control bit holds.
- R8: With `loc_mode`=1 and the flag set, the path is `scan_in` → lower segment → flag → `scan_out`.
- R9: While `loc_mode`=1, shift, capture and update edges leave both control stages unchanged.
- R10: In normal access the flag is off the path, and shift edges leave it unchanged.
- R11: `loc_mode` takes precedence over `diag_mode` when both are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_in | input | 1 | Serial data from the upstream side of the network |
| scan_out | output | 1 | Serial data toward the downstream side of the network |
| shift_en | input | 1 | Shift enable |
| capture_en | input | 1 | Capture enable |
| update_en | input | 1 | Update enable |
| seg_si | output | 1 | Serial data into the attached lower segment |
| seg_so | input | 1 | Serial data from the attached lower segment |
| irq_in | input | IRQ_W | Interrupt lines from the lower hierarchy |
| irq_out | output | 1 | Interrupt toward the parent |
| diag_mode | input | 1 | Diagnosis mode: flag always on the path |
| loc_mode | input | 1 | Localization mode: flags only, descend on set flag |

## Verification
The bench attaches a three-bit lower segment and runs random mixes of mode, enables and interrupt lines against a cycle model built from the requirements. It also drives directed sequences at the mode boundaries. A design that keyed the localization descent on the control bit instead of the flag would expose the lower segment's bits when the flag is clear, and would hide them when it is set. A cell that still updated its control bit during localization would reopen or close the segment after the host left that mode. A design that left the flag in the path during normal access would lengthen the path by one bit and shift the interrupt record away, which both the serial output and `irq_out` reveal. Overlapping diagnosis and localization modes check that localization wins.

// File: rtl/fsg_pkg.sv
package fsg_pkg;
  typedef enum logic [1:0] {
    FSG_NORMAL = 2'd0,
    FSG_DIAG   = 2'd1,
    FSG_LOC    = 2'd2
  } fsg_mode_e;
endpackage

// File: rtl/fsg_rst_sync.sv
module fsg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/fsg_mode_dec.sv
module fsg_mode_dec
  import fsg_pkg::*;
(
  input  logic      diag_mode,
  input  logic      loc_mode,
  output fsg_mode_e mode,
  output logic      flag_in_path,
  output logic      ctl_in_path
);
  always_comb begin
    if (loc_mode)       mode = FSG_LOC;
    else if (diag_mode) mode = FSG_DIAG;
    else                mode = FSG_NORMAL;
    flag_in_path = (mode != FSG_NORMAL);
    ctl_in_path  = (mode != FSG_LOC);
  end
endmodule

// File: rtl/fsg_ctl_bit.sv
module fsg_ctl_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic capture_en,
  input  logic shift_en,
  input  logic update_en,
  input  logic shift_d,
  output logic sh_q,
  output logic upd_q
);
  logic sh_d;
  logic upd_d;

  always_comb begin
    sh_d  = sh_q;
    upd_d = upd_q;
    if (active) begin
      if (capture_en)    sh_d = upd_q;
      else if (shift_en) sh_d = shift_d;
      if (update_en)     upd_d = sh_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= 1'b0;
      upd_q <= 1'b0;
    end else begin
      sh_q  <= sh_d;
      upd_q <= upd_d;
    end
  end
endmodule

// File: rtl/fsg_flag_bit.sv
module fsg_flag_bit #(
  parameter int IRQ_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_path,
  input  logic             capture_en,
  input  logic             shift_en,
  input  logic             shift_d,
  input  logic [IRQ_W-1:0] irq_in,
  output logic             flag_q,
  output logic             irq_out
);
  logic any_irq;
  logic flag_d;

  always_comb begin
    any_irq = |irq_in;
    flag_d  = flag_q;
    if (capture_en)               flag_d = any_irq;
    else if (shift_en && in_path) flag_d = shift_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign irq_out = flag_q | any_irq;
endmodule

// File: rtl/flagged_seg_gate.sv
module flagged_seg_gate
  import fsg_pkg::*;
#(
  parameter int IRQ_W     = 4,
  parameter int RST_STAGE = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scan_in,
  output logic             scan_out,
  input  logic             shift_en,
  input  logic             capture_en,
  input  logic             update_en,
  output logic             seg_si,
  input  logic             seg_so,
  input  logic [IRQ_W-1:0] irq_in,
  output logic             irq_out,
  input  logic             diag_mode,
  input  logic             loc_mode
);
  fsg_mode_e mode;
  logic      rst_sync_n;
  logic      flag_in_path;
  logic      ctl_in_path;
  logic      ctl_sh_q;
  logic      ctl_upd_q;
  logic      flag_q;
  logic      seg_open;
  logic      pre_ctl;
  logic      flag_d;

  fsg_rst_sync #(.STAGES(RST_STAGE)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  fsg_mode_dec u_dec (
    .diag_mode    (diag_mode),
    .loc_mode     (loc_mode),
    .mode         (mode),
    .flag_in_path (flag_in_path),
    .ctl_in_path  (ctl_in_path)
  );

  always_comb begin
    seg_open = (mode == FSG_LOC) ? flag_q : ctl_upd_q;
    pre_ctl  = seg_open ? seg_so : scan_in;
    flag_d   = ctl_in_path ? ctl_sh_q : pre_ctl;
  end

  fsg_ctl_bit u_ctl (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .active     (ctl_in_path),
    .capture_en (capture_en),
    .shift_en   (shift_en),
    .update_en  (update_en),
    .shift_d    (pre_ctl),
    .sh_q       (ctl_sh_q),
    .upd_q      (ctl_upd_q)
  );

  fsg_flag_bit #(.IRQ_W(IRQ_W)) u_flag (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .in_path    (flag_in_path),
    .capture_en (capture_en),
    .shift_en   (shift_en),
    .shift_d    (flag_d),
    .irq_in     (irq_in),
    .flag_q     (flag_q),
    .irq_out    (irq_out)
  );

  assign seg_si   = scan_in;
  assign scan_out = flag_in_path ? flag_q : ctl_sh_q;
endmodule

// File: rtl/fsg_chk.sv
module fsg_chk #(
  parameter int IRQ_W = 4
) (
  input logic             clk,
  input logic             rst_sync_n,
  input logic             scan_in,
  input logic             scan_out,
  input logic             seg_si,
  input logic             capture_en,
  input logic             loc_mode,
  input logic             diag_mode,
  input logic [IRQ_W-1:0] irq_in,
  input logic             irq_out,
  input logic             flag_q,
  input logic             ctl_upd_q,
  input logic             ctl_sh_q
);
  p_seg_feed_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    seg_si == scan_in);

  p_irq_up_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (irq_in != '0) |-> irq_out);

  p_loc_quiet_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (loc_mode && !irq_out) |-> !scan_out);

  p_capture_flag_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    capture_en |=> (flag_q == $past(|irq_in)));

  p_loc_freeze_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    loc_mode |=> ($stable(ctl_upd_q) && $stable(ctl_sh_q)));

  p_norm_flag_hold_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!loc_mode && !diag_mode && !capture_en) |=> $stable(flag_q));

  p_loc_over_diag_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (loc_mode && diag_mode && !flag_q) |-> !scan_out);
endmodule

bind flagged_seg_gate fsg_chk #(.IRQ_W(IRQ_W)) u_fsg_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .scan_in    (scan_in),
  .scan_out   (scan_out),
  .seg_si     (seg_si),
  .capture_en (capture_en),
  .loc_mode   (loc_mode),
  .diag_mode  (diag_mode),
  .irq_in     (irq_in),
  .irq_out    (irq_out),
  .flag_q     (flag_q),
  .ctl_upd_q  (ctl_upd_q),
  .ctl_sh_q   (ctl_sh_q)
);

// File: tb/test_flagged_seg_gate.sv
module test_flagged_seg_gate;
  localparam int IRQ_W   = 4;
  localparam int SEG_LEN = 3;
  localparam int OP_IDLE = 0, OP_SHIFT = 1, OP_CAP = 2, OP_UPD = 3;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             scan_in = 1'b0, shift_en = 1'b0, capture_en = 1'b0, update_en = 1'b0;
  logic             diag_mode = 1'b0, loc_mode = 1'b0;
  logic [IRQ_W-1:0] irq_in = '0;
  logic             scan_out, seg_si, seg_so, irq_out;
  logic [SEG_LEN-1:0] seg_q = '0;

  int checks = 0;
  int fails  = 0;

  // spec model state
  logic m_sh = 1'b0, m_upd = 1'b0, m_flag = 1'b0;

  always #4 clk = ~clk;

  flagged_seg_gate #(.IRQ_W(IRQ_W)) i_flagged_seg_gate (
    .clk(clk), .rst_n(rst_n), .scan_in(scan_in), .scan_out(scan_out),
    .shift_en(shift_en), .capture_en(capture_en), .update_en(update_en),
    .seg_si(seg_si), .seg_so(seg_so), .irq_in(irq_in), .irq_out(irq_out),
    .diag_mode(diag_mode), .loc_mode(loc_mode)
  );

  // lower segment: a plain shift register stepping on every shift edge
  assign seg_so = seg_q[SEG_LEN-1];
  always @(posedge clk) if (shift_en) seg_q <= {seg_q[SEG_LEN-2:0], seg_si};

  function automatic logic exp_open(logic l);
    return l ? m_flag : m_upd;
  endfunction

  function automatic logic exp_out(logic d, logic l);
    return (l || d) ? m_flag : m_sh;
  endfunction

  task automatic check(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(logic d, logic l, int op, logic si, logic [IRQ_W-1:0] irq, string tag);
    logic pre, n_sh, n_upd, n_flag;
    string t;
    @(negedge clk);
    diag_mode = d; loc_mode = l; scan_in = si; irq_in = irq;
    shift_en = (op == OP_SHIFT); capture_en = (op == OP_CAP); update_en = (op == OP_UPD);
    #1;
    if (tag != "") t = tag;
    else if (l)    t = m_flag ? "R8" : "R7";
    else if (d)    t = "R5";
    else           t = "R2";
    check(t, scan_out, exp_out(d, l));
    check("R6", irq_out, m_flag | (|irq));
    check("R3", seg_si, si);
    pre = exp_open(l) ? seg_so : si;
    n_sh = m_sh; n_upd = m_upd; n_flag = m_flag;
    if (!l) begin
      if (op == OP_CAP)        n_sh = m_upd;
      else if (op == OP_SHIFT) n_sh = pre;
      if (op == OP_UPD)        n_upd = m_sh;
    end
    if (op == OP_CAP) n_flag = |irq;
    else if (op == OP_SHIFT && (l || d)) n_flag = l ? pre : m_sh;
    @(posedge clk);
    m_sh = n_sh; m_upd = n_upd; m_flag = n_flag;
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [1:0] r;
    void'($urandom(32'h5eed_1687));
    repeat (3) @(posedge clk);
    #1;
    check("R1", scan_out, 1'b0);
    check("R1", irq_out, 1'b0);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) step(0, 0, OP_IDLE, 0, '0, "R1");
    // R2: closed segment, one-bit path
    step(0, 0, OP_SHIFT, 1, '0, "R2");
    step(0, 0, OP_SHIFT, 0, '0, "R2");
    step(0, 0, OP_SHIFT, 1, '0, "R2");
    // R3: open the segment and stream through it
    step(0, 0, OP_UPD, 0, '0, "R3");
    for (int i = 0; i < 6; i++) step(0, 0, OP_SHIFT, i[0], '0, "R3");
    // R4: capture copies update stage (1) into the shift stage
    step(0, 0, OP_SHIFT, 0, '0, "R4");
    step(0, 0, OP_CAP, 0, '0, "R4");
    step(0, 0, OP_IDLE, 0, '0, "R4");
    // R5/R6: diagnosis capture of interrupt lines
    step(1, 0, OP_CAP, 0, 4'b0010, "R5");
    step(1, 0, OP_IDLE, 0, '0, "R5");
    for (int i = 0; i < 4; i++) step(1, 0, OP_SHIFT, ~i[0], '0, "R5");
    // R8: set flag, localization descends into the segment
    step(0, 0, OP_CAP, 0, 4'b1000, "R6");
    for (int i = 0; i < 5; i++) step(0, 1, OP_SHIFT, i[1], '0, "R8");
    // R7: clear flag, localization bypasses an open segment
    step(0, 0, OP_CAP, 0, '0, "R6");
    step(0, 0, OP_SHIFT, 1, '0, "R2");
    step(0, 0, OP_UPD, 0, '0, "R3");
    for (int i = 0; i < 3; i++) step(0, 1, OP_SHIFT, 0, '0, "R7");
    // R11: both modes, localization wins
    step(1, 1, OP_IDLE, 0, '0, "R11");
    step(1, 1, OP_SHIFT, 1, '0, "R11");
    step(1, 1, OP_SHIFT, 0, '0, "R11");
    // R9: controls frozen in localization, then observed outside it
    step(0, 1, OP_UPD, 0, '0, "R9");
    step(0, 1, OP_CAP, 0, '0, "R9");
    step(0, 1, OP_SHIFT, 1, '0, "R9");
    step(0, 0, OP_IDLE, 0, '0, "R9");
    step(0, 0, OP_CAP, 0, '0, "R9");
    step(0, 0, OP_IDLE, 0, '0, "R9");
    // R10: flag held through normal shifts, seen on irq_out
    step(1, 0, OP_CAP, 0, 4'b0001, "R5");
    for (int i = 0; i < 4; i++) step(0, 0, OP_SHIFT, 0, '0, "R10");
    check("R10", irq_out, 1'b1);
    // random mix
    for (int i = 0; i < 4000; i++) begin
      int op;
      r  = 2'($urandom_range(0, 3));
      op = ($urandom_range(0, 9) < 6) ? OP_SHIFT : int'($urandom_range(0, 3));
      step(r[0], r[1] & ($urandom_range(0, 2) == 0), op, 1'($urandom_range(0, 1)),
           ($urandom_range(0, 3) == 0) ? IRQ_W'($urandom_range(1, 15)) : '0, "");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule